// File: doc/BRIEF.md
# Envelope Threshold Comparator with Hysteresis

This block watches a stream of unsigned envelope samples, each qualified by a valid strobe, and decides when the envelope crosses a programmable threshold. A hysteresis band keeps the decision from chattering when the envelope hovers near the threshold. A polarity bit chooses the crossing: polarity 0 catches a rising envelope, polarity 1 catches a falling one. The hysteresis and the polarity share one control word, with the polarity in the top bit.

The block keeps a level bit that shows whether the comparator is in its active state. On every transition into the active state it does three things. It emits a one-cycle pulse that an external timer uses to stop counting. It sets a sticky flag that stays set until software clears it. Through that flag it raises an interrupt, gated by an enable. Samples that arrive with the strobe low are ignored.

Top module: `echo_cross_detect`

## Requirements
- R1: With polarity 0 (ctrl bit 15 = 0, hysteresis = ctrl bits 14:0), a valid sample strictly greater than the threshold sets `level_o`. The change is visible after the clock edge that samples the strobe. A sample equal to the threshold does not set it.
- R2: With polarity 0, `level_o` clears only when a valid sample is strictly below the threshold minus the hysteresis. That difference saturates at 0. Samples between the two bounds hold the level.
- R3: With polarity 1 (ctrl bit 15 = 1), a valid sample strictly below the threshold sets `level_o`.
- R4: With polarity 1, `level_o` clears only when a valid sample is strictly above the threshold plus the hysteresis. That sum saturates at 65535. Samples between the two bounds hold the level.
- R5: While `smp_vld_i` is low, the sample has no effect on `level_o`, `stop_o` or `flag_o`.
- R6: `stop_o` is high for exactly the one cycle in which `level_o` has just gone from 0 to 1, and it is low at all other times.
- R7: `flag_o` is set by every transition into the active state. It stays set until `flag_clr_i` is sampled high, and it reads 0 after that edge.
- R8: When a transition into the active state and `flag_clr_i` occur at the same edge, `flag_o` is 1 after that edge.
- R9: `irq_o` is the registered AND of the next flag value and `irq_en_i`, so it follows the enable one edge later.
- R10: A synchronous active-high `rst` drives `level_o`, `stop_o`, `flag_o` and `irq_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_i | input | 16 | Unsigned envelope sample |
| thr_i | input | 16 | Unsigned threshold |
| ctrl_i | input | 16 | Bit 15: polarity (0 rising, 1 falling). Bits 14:0: hysteresis |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the sticky flag |
| level_o | output | 1 | Comparator level (1 = active) |
| flag_o | output | 1 | Sticky crossing flag |
| irq_o | output | 1 | Gated interrupt request |
| stop_o | output | 1 | One-cycle timer stop pulse |

## Verification
The bench builds the block with its defaults: a 16-bit sample and a 15-bit hysteresis field. With these widths a 0x100 hysteresis on a threshold of 0xFFC0 pushes the release bound past full scale, which exercises the upper saturation. A hysteresis of 100 on a threshold of 50 exercises the clamp at zero. The same widths place the polarity in bit 15, so the table drives both polarities. It also covers the exact-bound samples that must hold the level and a switch of polarity while the level is active.

// File: rtl/echo_cross_pkg.sv
package echo_cross_pkg;
  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } xd_pol_e;

  typedef struct packed {
    logic enter;
    logic leave;
  } xd_decision_t;
endpackage

// File: rtl/xd_band_calc.sv
module xd_band_calc #(
  parameter int W  = 16,
  parameter int HW = 15
) (
  input  logic [W-1:0]  thr_i,
  input  logic [HW-1:0] hyst_i,
  output logic [W-1:0]  lo_o,
  output logic [W-1:0]  hi_o
);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] hyst_ext;
  logic [W:0]   sum_wide;

  assign hyst_ext = W'(hyst_i);
  assign sum_wide = {1'b0, thr_i} + {1'b0, hyst_ext};

  // lower release bound, clamped at zero
  assign lo_o = (thr_i > hyst_ext) ? (thr_i - hyst_ext) : '0;
  // upper release bound, clamped at full scale
  assign hi_o = sum_wide[W] ? FULL : sum_wide[W-1:0];
endmodule

// File: rtl/xd_cross_eval.sv
module xd_cross_eval
  import echo_cross_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]  smp_i,
  input  logic [W-1:0]  thr_i,
  input  logic [W-1:0]  lo_i,
  input  logic [W-1:0]  hi_i,
  input  xd_pol_e       pol_i,
  output xd_decision_t  dec_o
);
  always_comb begin
    unique case (pol_i)
      POL_RISE: begin
        dec_o.enter = smp_i > thr_i;
        dec_o.leave = smp_i < lo_i;
      end
      default: begin
        dec_o.enter = smp_i < thr_i;
        dec_o.leave = smp_i > hi_i;
      end
    endcase
  end
endmodule

// File: rtl/xd_level_track.sv
module xd_level_track
  import echo_cross_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  xd_decision_t dec_i,
  output logic         rise_evt_o,
  output logic         level_o,
  output logic         stop_o
);
  logic level_q;
  logic stop_q;
  logic level_d;

  always_comb begin
    rise_evt_o = vld_i && !level_q && dec_i.enter;
    level_d    = level_q;
    if (rise_evt_o) begin
      level_d = 1'b1;
    end else if (vld_i && level_q && dec_i.leave) begin
      level_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      level_q <= level_d;
      stop_q  <= rise_evt_o;
    end
  end

  assign level_o = level_q;
  assign stop_o  = stop_q;
endmodule

// File: rtl/xd_irq_flag.sv
module xd_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic irq_q;
  logic flag_d;

  // a new event outranks a clear arriving at the same edge
  assign flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/echo_cross_detect.sv
module echo_cross_detect
  import echo_cross_pkg::*;
#(
  parameter int W  = 16,
  parameter int HW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld_i,
  input  logic [W-1:0]  smp_i,
  input  logic [W-1:0]  thr_i,
  input  logic [HW:0]   ctrl_i,
  input  logic          irq_en_i,
  input  logic          flag_clr_i,
  output logic          level_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic          stop_o
);
  localparam int POL_BIT = HW;

  logic [W-1:0]  lo_bound;
  logic [W-1:0]  hi_bound;
  xd_pol_e       pol;
  xd_decision_t  dec;
  logic          rise_evt;

  assign pol = xd_pol_e'(ctrl_i[POL_BIT]);

  xd_band_calc #(.W(W), .HW(HW)) u_band (
    .thr_i  (thr_i),
    .hyst_i (ctrl_i[HW-1:0]),
    .lo_o   (lo_bound),
    .hi_o   (hi_bound)
  );

  xd_cross_eval #(.W(W)) u_eval (
    .smp_i (smp_i),
    .thr_i (thr_i),
    .lo_i  (lo_bound),
    .hi_i  (hi_bound),
    .pol_i (pol),
    .dec_o (dec)
  );

  xd_level_track u_level (
    .clk        (clk),
    .rst        (rst),
    .vld_i      (smp_vld_i),
    .dec_i      (dec),
    .rise_evt_o (rise_evt),
    .level_o    (level_o),
    .stop_o     (stop_o)
  );

  xd_irq_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (rise_evt),
    .clr_i  (flag_clr_i),
    .en_i   (irq_en_i),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/echo_cross_detect_chk.sv
module echo_cross_detect_chk #(
  parameter int W  = 16,
  parameter int HW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_vld_i,
  input logic [W-1:0]  smp_i,
  input logic [W-1:0]  thr_i,
  input logic [HW:0]   ctrl_i,
  input logic          irq_en_i,
  input logic          flag_clr_i,
  input logic          level_o,
  input logic          flag_o,
  input logic          irq_o,
  input logic          stop_o
);
  // R5
  level_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(level_o) && !$past(rst)) |-> $past(smp_vld_i));

  // R6
  stop_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    stop_o == $rose(level_o));

  // R6
  stop_single_chk: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !stop_o);

  // R7
  stop_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> flag_o);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_o) && !$past(flag_clr_i) && !$past(rst)) |-> flag_o);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_clr_i) && !stop_o) |-> !flag_o);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_o && $past(irq_en_i)));

  // R9
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_en_i) && flag_o) |-> irq_o);
endmodule

bind echo_cross_detect echo_cross_detect_chk #(.W(W), .HW(HW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_vld_i  (smp_vld_i),
  .smp_i      (smp_i),
  .thr_i      (thr_i),
  .ctrl_i     (ctrl_i),
  .irq_en_i   (irq_en_i),
  .flag_clr_i (flag_clr_i),
  .level_o    (level_o),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .stop_o     (stop_o)
);

// File: tb/test_echo_cross_detect.sv
`timescale 1ns/1ps
module test_echo_cross_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_vld_i = 1'b0;
  logic [15:0] smp_i = '0;
  logic [15:0] thr_i = '0;
  logic [15:0] ctrl_i = '0;
  logic        irq_en_i = 1'b0;
  logic        flag_clr_i = 1'b0;
  logic        level_o, flag_o, irq_o, stop_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  echo_cross_detect i_echo_cross_detect (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
    .thr_i(thr_i), .ctrl_i(ctrl_i), .irq_en_i(irq_en_i),
    .flag_clr_i(flag_clr_i), .level_o(level_o), .flag_o(flag_o),
    .irq_o(irq_o), .stop_o(stop_o)
  );

  // {vld, sample, threshold, ctrl, expected level, expected stop}
  localparam logic [50:0] VEC [0:19] = '{
    {1'b1, 16'd500,   16'd1000,  16'h0064, 1'b0, 1'b0}, // R1 below
    {1'b1, 16'd1000,  16'd1000,  16'h0064, 1'b0, 1'b0}, // R1 equal
    {1'b1, 16'd1001,  16'd1000,  16'h0064, 1'b1, 1'b1}, // R1 enter
    {1'b1, 16'd1200,  16'd1000,  16'h0064, 1'b1, 1'b0}, // R6 no repeat
    {1'b1, 16'd950,   16'd1000,  16'h0064, 1'b1, 1'b0}, // R2 in band
    {1'b1, 16'd900,   16'd1000,  16'h0064, 1'b1, 1'b0}, // R2 at bound
    {1'b1, 16'd899,   16'd1000,  16'h0064, 1'b0, 1'b0}, // R2 release
    {1'b1, 16'd950,   16'd1000,  16'h0064, 1'b0, 1'b0}, // R2 stays low
    {1'b0, 16'd5000,  16'd1000,  16'h0064, 1'b0, 1'b0}, // R5 ignored
    {1'b1, 16'd5000,  16'd1000,  16'h0064, 1'b1, 1'b1}, // R1 enter
    {1'b1, 16'd5000,  16'd1000,  16'h8064, 1'b0, 1'b0}, // R4 release
    {1'b1, 16'd1050,  16'd1000,  16'h8064, 1'b0, 1'b0}, // R3 above
    {1'b1, 16'd999,   16'd1000,  16'h8064, 1'b1, 1'b1}, // R3 enter
    {1'b1, 16'd1100,  16'd1000,  16'h8064, 1'b1, 1'b0}, // R4 at bound
    {1'b1, 16'd1101,  16'd1000,  16'h8064, 1'b0, 1'b0}, // R4 release
    {1'b1, 16'd51,    16'd50,    16'h0064, 1'b1, 1'b1}, // R1 enter
    {1'b1, 16'd0,     16'd50,    16'h0064, 1'b1, 1'b0}, // R2 clamp 0
    {1'b1, 16'd0,     16'hFFC0,  16'h8100, 1'b1, 1'b0}, // R3 already on
    {1'b1, 16'hFFFF,  16'hFFC0,  16'h8100, 1'b1, 1'b0}, // R4 clamp top
    {1'b1, 16'd1000,  16'd1000,  16'h0000, 1'b1, 1'b0}  // R2 zero band
  };

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic exp_l, exp_s;
    repeat (3) @(negedge clk);
    check("R10", "level", level_o, 1'b0);
    check("R10", "stop",  stop_o,  1'b0);
    check("R10", "flag",  flag_o,  1'b0);
    check("R10", "irq",   irq_o,   1'b0);
    rst = 1'b0;
    exp_l = 1'b0;
    exp_s = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R1-table level", $sformatf("vec %0d", i - 1), level_o, exp_l);
        check("R6 table stop", $sformatf("vec %0d", i - 1), stop_o, exp_s);
      end
      smp_vld_i = VEC[i][50];
      smp_i     = VEC[i][49:34];
      thr_i     = VEC[i][33:18];
      ctrl_i    = VEC[i][17:2];
      exp_l     = VEC[i][1];
      exp_s     = VEC[i][0];
    end
    @(negedge clk);
    check("R2 table level", "vec 19", level_o, exp_l);
    check("R6 table stop", "vec 19", stop_o, exp_s);
    smp_vld_i = 1'b0;
    smp_i = 16'd0;

    // level is now 1 with zero band, polarity 0, threshold 1000
    @(negedge clk);
    check("R5", "level hold, no strobe", level_o, 1'b1);
    check("R7", "flag sticky", flag_o, 1'b1);
    check("R9", "irq masked", irq_o, 1'b0);
    irq_en_i = 1'b1;
    @(negedge clk);
    check("R9", "irq enabled", irq_o, 1'b1);

    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    check("R7", "flag cleared", flag_o, 1'b0);
    check("R9", "irq after clear", irq_o, 1'b0);

    // release the level, then re-enter while clearing
    smp_vld_i = 1'b1;
    smp_i = 16'd999;
    @(negedge clk);
    check("R2", "release at 999", level_o, 1'b0);
    check("R7", "no flag on release", flag_o, 1'b0);
    smp_i = 16'd2000;
    flag_clr_i = 1'b1;
    @(negedge clk);
    smp_vld_i = 1'b0;
    flag_clr_i = 1'b0;
    check("R8", "set beats clear", flag_o, 1'b1);
    check("R8", "stop pulse", stop_o, 1'b1);
    check("R8", "irq on set", irq_o, 1'b1);
    @(negedge clk);
    check("R6", "stop one cycle", stop_o, 1'b0);
    check("R7", "flag held", flag_o, 1'b1);

    rst = 1'b1;
    @(negedge clk);
    check("R10", "level after reset", level_o, 1'b0);
    check("R10", "flag after reset",  flag_o,  1'b0);
    check("R10", "irq after reset",   irq_o,   1'b0);
    check("R10", "stop after reset",  stop_o,  1'b0);
    rst = 1'b0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule